// File: doc/BRIEF.md
# Three-Phase Gate-Drive Protection Logic

This block is the digital guard that sits between a motor controller's six PWM commands and the gate drivers of a three-phase half-bridge. For every phase it accepts an upper and a lower switch command. It turns these into gate-enable outputs, but only while the protections allow it. An enable input, an overcurrent trip flag, a main-supply undervoltage flag and one undervoltage flag per upper-side floating supply all arrive as asynchronous digital levels. Each of them passes through a two-flop synchronizer before any logic uses it.

The block prevents shoot-through by refusing a phase when both of its commands are on. An overcurrent trip removes all six gates at once and pulls the open-drain fault pin low. The fault releases itself a programmed number of cycles after the trip has gone away. A main-supply undervoltage removes all gates and recovers immediately. An upper-supply undervoltage removes only that phase's upper gate, and that gate then stays blocked until its command has been seen low. Command edges that do not stay stable for a minimum number of cycles are filtered out.

Top module: `gdrv_guard`

## Requirements
- R1: When a phase's filtered upper and lower commands are both 1, both gates of that phase are 0. A single active command drives only its own gate to 1.
- R2: While `drv_en` is 0, all six gate outputs are 0, whatever the commands are.
- R3: While `oc_trip` is 1, all six gates are 0 and `flt_pull` is 1. Both take effect within four clock cycles of the trip.
- R4: `flt_pull` stays 1 for as long as the trip is present. It falls exactly `CLR_CYC` cycles after the synchronized trip goes low, and the gates then follow their commands again.
- R5: While `main_uv` is 1, all six gates are 0. When it returns to 0, the gates follow their commands with no need for any command to toggle.
- R6: `hs_uv[i]` = 1 forces `hi_gate[i]` to 0 and leaves the other phases and all lower gates untouched.
- R7: After `hs_uv[i]` returns to 0, `hi_gate[i]` stays 0 until `hi_cmd[i]` has been seen low after filtering. Only a later high command turns it on again.
- R8: Lower gates never depend on any earlier command history. They recover by themselves after a main-supply undervoltage or a fault.
- R9: A command change held for fewer than `MIN_PW_CYC` cycles has no effect on the gates. A change held for `MIN_PW_CYC` cycles or more is passed. Both rising and falling edges are filtered.
- R10: During and after reset, all gates and `flt_pull` are 0. Every upper gate is blocked until its command has first been seen low, so a command already high at reset does not turn that gate on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hi_cmd | input | PHASES | Upper switch commands, bit i = phase i, 1 = on |
| lo_cmd | input | PHASES | Lower switch commands, bit i = phase i, 1 = on |
| drv_en | input | 1 | Driver enable, 1 = gates allowed |
| oc_trip | input | 1 | Overcurrent comparator flag, 1 = trip |
| main_uv | input | 1 | Main supply undervoltage flag, 1 = low supply |
| hs_uv | input | PHASES | Upper floating supply undervoltage flags, 1 = low supply |
| hi_gate | output | PHASES | Upper gate enables |
| lo_gate | output | PHASES | Lower gate enables |
| flt_pull | output | 1 | Output-enable of the open-drain fault pin, 1 = pin pulled low |

## Verification
The checker watches on every cycle that no phase ever has both gates on. It also checks that any synchronized trip, main-supply undervoltage or disable is followed by all gates off, that an undervoltage or a block flag on an upper supply keeps that upper gate off, and that the fault never releases while the trip is still seen. Only the bench's scenarios can show the exact fault-clear interval, the pulse-width boundary one cycle each side of `MIN_PW_CYC`, and the fact that an upper gate stays blocked after recovery until its command drops and rises again. The same holds for the lower side coming back with no command toggle.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;

  // Decides whether an upper gate may conduct this cycle.
  function automatic logic upper_pass(input logic allow, input logic hi,
                                      input logic lo, input logic uv,
                                      input logic blocked);
    return allow & hi & ~lo & ~uv & ~blocked;
  endfunction

  // Decides whether a lower gate may conduct this cycle.
  function automatic logic lower_pass(input logic allow, input logic hi,
                                      input logic lo);
    return allow & lo & ~hi;
  endfunction

  // Global permission shared by all six gates.
  function automatic logic global_allow(input logic en, input logic trip,
                                        input logic muv, input logic fault);
    return en & ~trip & ~muv & ~fault;
  endfunction

  // Counter width needed to hold the value n-1 (at least one bit).
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n > 2) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/gdrv_sync.sv
module gdrv_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[s] <= RST_VAL;
        else if (s == 0) chain[s] <= d;
        else chain[s] <= chain[(s == 0) ? 0 : s - 1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/gdrv_pwfilt.sv
module gdrv_pwfilt
  import gdrv_pkg::*;
#(
  parameter int unsigned MIN_PW  = 10,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic filt
);
  localparam int unsigned CW = cnt_width(MIN_PW);
  localparam logic [CW-1:0] LOAD = CW'(MIN_PW - 1);

  logic [CW-1:0] cnt;
  logic          differs;
  logic          accept;

  assign differs = raw ^ filt;
  assign accept  = differs && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt <= RST_VAL;
      cnt  <= LOAD;
    end else if (!differs) begin
      cnt <= LOAD;
    end else if (accept) begin
      filt <= raw;
      cnt  <= LOAD;
    end else begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/gdrv_fault_timer.sv
module gdrv_fault_timer
  import gdrv_pkg::*;
#(
  parameter int unsigned CLR_CYC = 180000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trip,
  output logic fault
);
  localparam int unsigned CW = cnt_width(CLR_CYC);
  localparam logic [CW-1:0] LOAD = CW'(CLR_CYC - 1);

  logic [CW-1:0] remain;
  logic          expire;

  assign expire = fault && !trip && (remain == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fault  <= 1'b0;
      remain <= LOAD;
    end else if (trip) begin
      fault  <= 1'b1;
      remain <= LOAD;
    end else if (expire) begin
      fault  <= 1'b0;
      remain <= LOAD;
    end else if (fault) begin
      remain <= remain - 1'b1;
    end
  end
endmodule

// File: rtl/gdrv_phase.sv
module gdrv_phase
  import gdrv_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic allow,
  input  logic hi_f,
  input  logic lo_f,
  input  logic uv,
  output logic hi_gate,
  output logic lo_gate,
  output logic blocked
);
  logic rearm;

  // Blocking is released only once the supply is good and the command is low.
  assign rearm = ~uv & ~hi_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) blocked <= 1'b1;
    else if (uv) blocked <= 1'b1;
    else if (rearm) blocked <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_gate <= 1'b0;
      lo_gate <= 1'b0;
    end else begin
      hi_gate <= upper_pass(allow, hi_f, lo_f, uv, blocked);
      lo_gate <= lower_pass(allow, hi_f, lo_f);
    end
  end
endmodule

// File: rtl/gdrv_guard.sv
module gdrv_guard
  import gdrv_pkg::*;
#(
  parameter int unsigned PHASES      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MIN_PW_CYC  = 10,
  parameter int unsigned CLR_CYC     = 180000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PHASES-1:0] hi_cmd,
  input  logic [PHASES-1:0] lo_cmd,
  input  logic              drv_en,
  input  logic              oc_trip,
  input  logic              main_uv,
  input  logic [PHASES-1:0] hs_uv,
  output logic [PHASES-1:0] hi_gate,
  output logic [PHASES-1:0] lo_gate,
  output logic              flt_pull
);
  localparam int unsigned NSYNC = 3 * PHASES + 3;
  // Upper commands reset to "high" so a first turn-on needs a seen-low command.
  localparam logic [NSYNC-1:0] SYNC_RST =
    {{(PHASES + 3){1'b0}}, {PHASES{1'b0}}, {PHASES{1'b1}}};

  logic [NSYNC-1:0]  async_vec;
  logic [NSYNC-1:0]  sync_vec;
  logic [PHASES-1:0] hi_s, lo_s, hs_uv_s;
  logic              en_s, trip_s, main_uv_s;
  logic [PHASES-1:0] hi_f, lo_f, blk;
  logic              fault_q;
  logic              allow;

  assign async_vec = {hs_uv, main_uv, oc_trip, drv_en, lo_cmd, hi_cmd};

  gdrv_sync #(
    .W(NSYNC), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .d(async_vec), .q(sync_vec)
  );

  assign hi_s      = sync_vec[PHASES-1:0];
  assign lo_s      = sync_vec[2*PHASES-1:PHASES];
  assign en_s      = sync_vec[2*PHASES];
  assign trip_s    = sync_vec[2*PHASES+1];
  assign main_uv_s = sync_vec[2*PHASES+2];
  assign hs_uv_s   = sync_vec[NSYNC-1:2*PHASES+3];

  gdrv_fault_timer #(.CLR_CYC(CLR_CYC)) u_fault (
    .clk(clk), .rst_n(rst_n), .trip(trip_s), .fault(fault_q)
  );

  assign allow = global_allow(en_s, trip_s, main_uv_s, fault_q);

  genvar p;
  generate
    for (p = 0; p < PHASES; p++) begin : g_ph
      gdrv_pwfilt #(.MIN_PW(MIN_PW_CYC), .RST_VAL(1'b1)) u_hi_flt (
        .clk(clk), .rst_n(rst_n), .raw(hi_s[p]), .filt(hi_f[p])
      );
      gdrv_pwfilt #(.MIN_PW(MIN_PW_CYC), .RST_VAL(1'b0)) u_lo_flt (
        .clk(clk), .rst_n(rst_n), .raw(lo_s[p]), .filt(lo_f[p])
      );
      gdrv_phase u_phase (
        .clk(clk), .rst_n(rst_n), .allow(allow),
        .hi_f(hi_f[p]), .lo_f(lo_f[p]), .uv(hs_uv_s[p]),
        .hi_gate(hi_gate[p]), .lo_gate(lo_gate[p]), .blocked(blk[p])
      );
    end
  endgenerate

  assign flt_pull = fault_q;
endmodule

// File: rtl/gdrv_guard_chk.sv
module gdrv_guard_chk #(
  parameter int unsigned PHASES = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic [PHASES-1:0] hi_gate,
  input logic [PHASES-1:0] lo_gate,
  input logic              flt_pull,
  input logic              en_s,
  input logic              trip_s,
  input logic              main_uv_s,
  input logic [PHASES-1:0] hs_uv_s,
  input logic [PHASES-1:0] blk,
  input logic [PHASES-1:0] hi_f,
  input logic [PHASES-1:0] lo_f
);
  a_r1_no_shoot_through: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_gate & lo_gate) == '0);

  a_r1_both_cmd_off: assert property (@(posedge clk) disable iff (!rst_n)
    ((hi_f & lo_f) != '0) |=> (((hi_gate | lo_gate) & $past(hi_f & lo_f)) == '0));

  a_r2_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> (hi_gate == '0 && lo_gate == '0));

  a_r3_trip_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
    trip_s |=> (flt_pull && hi_gate == '0 && lo_gate == '0));

  a_r3_fault_gates_off: assert property (@(posedge clk) disable iff (!rst_n)
    flt_pull |-> (hi_gate == '0 && lo_gate == '0));

  a_r4_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flt_pull) |-> !$past(trip_s));

  a_r5_main_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    main_uv_s |=> (hi_gate == '0 && lo_gate == '0));

  a_r6_upper_uv_off: assert property (@(posedge clk) disable iff (!rst_n)
    (hs_uv_s != '0) |=> ((hi_gate & $past(hs_uv_s)) == '0));

  a_r7_blocked_off: assert property (@(posedge clk) disable iff (!rst_n)
    (blk != '0) |=> ((hi_gate & $past(blk)) == '0));
endmodule

bind gdrv_guard gdrv_guard_chk #(.PHASES(PHASES)) u_chk (
  .clk(clk), .rst_n(rst_n), .hi_gate(hi_gate), .lo_gate(lo_gate),
  .flt_pull(flt_pull), .en_s(en_s), .trip_s(trip_s), .main_uv_s(main_uv_s),
  .hs_uv_s(hs_uv_s), .blk(blk), .hi_f(hi_f), .lo_f(lo_f)
);

// File: tb/gdrv_guard_bench.sv
`timescale 1ns/1ps
module gdrv_guard_bench;
  localparam int unsigned PH     = 3;
  localparam int unsigned MINPW  = 4;
  localparam int unsigned CLR    = 40;
  localparam int unsigned SETTLE = 14;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [PH-1:0] hi_cmd = '1;
  logic [PH-1:0] lo_cmd = '0;
  logic          drv_en = 1'b1;
  logic          oc_trip = 1'b0;
  logic          main_uv = 1'b0;
  logic [PH-1:0] hs_uv = '0;
  logic [PH-1:0] hi_gate, lo_gate;
  logic          flt_pull;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gdrv_guard #(
    .PHASES(PH), .SYNC_STAGES(2), .MIN_PW_CYC(MINPW), .CLR_CYC(CLR)
  ) u_gdrv_guard (
    .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd(lo_cmd),
    .drv_en(drv_en), .oc_trip(oc_trip), .main_uv(main_uv), .hs_uv(hs_uv),
    .hi_gate(hi_gate), .lo_gate(lo_gate), .flt_pull(flt_pull)
  );

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic gates_are(input string tag, input logic [PH-1:0] eh,
                           input logic [PH-1:0] el);
    chk({tag, " hi_gate"}, 32'(hi_gate), 32'(eh));
    chk({tag, " lo_gate"}, 32'(lo_gate), 32'(el));
  endtask

  task automatic t_reset;
    wait_cyc(3);
    gates_are("R10 in reset", '0, '0);
    chk("R10 in reset flt_pull", 32'(flt_pull), 0);
    rst_n = 1'b1;
    wait_cyc(SETTLE);
    gates_are("R10 high cmd at reset stays off", '0, '0);
    chk("R10 flt_pull after reset", 32'(flt_pull), 0);
    hi_cmd = '0;
    wait_cyc(SETTLE);
    hi_cmd = 3'b001;
    wait_cyc(SETTLE);
    gates_are("R10 turn-on after low seen", 3'b001, '0);
  endtask

  task automatic t_interlock;
    hi_cmd = 3'b010; lo_cmd = 3'b100;
    wait_cyc(SETTLE);
    gates_are("R1 single commands", 3'b010, 3'b100);
    hi_cmd = 3'b011; lo_cmd = 3'b001;
    wait_cyc(SETTLE);
    gates_are("R1 phase0 both on", 3'b010, 3'b000);
    hi_cmd = 3'b000; lo_cmd = 3'b111;
    wait_cyc(SETTLE);
    gates_are("R1 all lower", 3'b000, 3'b111);
  endtask

  task automatic t_enable;
    hi_cmd = 3'b100; lo_cmd = 3'b011;
    wait_cyc(SETTLE);
    drv_en = 1'b0;
    wait_cyc(6);
    gates_are("R2 disabled", '0, '0);
    drv_en = 1'b1;
    wait_cyc(6);
    gates_are("R2 re-enabled", 3'b100, 3'b011);
  endtask

  task automatic t_trip;
    hi_cmd = 3'b001; lo_cmd = 3'b010;
    wait_cyc(SETTLE);
    oc_trip = 1'b1;
    wait_cyc(4);
    gates_are("R3 trip shutdown", '0, '0);
    chk("R3 fault pin pulled", 32'(flt_pull), 1);
    wait_cyc(2 * CLR);
    chk("R4 held while trip present", 32'(flt_pull), 1);
    oc_trip = 1'b0;
    wait_cyc(CLR - 2);
    chk("R4 still held before clear time", 32'(flt_pull), 1);
    gates_are("R4 gates off before clear", '0, '0);
    wait_cyc(6);
    chk("R4 released after clear time", 32'(flt_pull), 0);
    gates_are("R8 R4 gates resume", 3'b001, 3'b010);
  endtask

  task automatic t_main_uv;
    hi_cmd = 3'b100; lo_cmd = 3'b001;
    wait_cyc(SETTLE);
    main_uv = 1'b1;
    wait_cyc(5);
    gates_are("R5 main undervoltage", '0, '0);
    main_uv = 1'b0;
    wait_cyc(5);
    gates_are("R5 R8 immediate resume", 3'b100, 3'b001);
  endtask

  task automatic t_upper_uv;
    hi_cmd = 3'b011; lo_cmd = 3'b100;
    wait_cyc(SETTLE);
    gates_are("R6 before upper uv", 3'b011, 3'b100);
    hs_uv = 3'b001;
    wait_cyc(5);
    gates_are("R6 R8 only phase0 upper off", 3'b010, 3'b100);
    hs_uv = 3'b000;
    wait_cyc(SETTLE);
    gates_are("R7 still blocked after recovery", 3'b010, 3'b100);
    hi_cmd = 3'b010;
    wait_cyc(SETTLE);
    hi_cmd = 3'b011;
    wait_cyc(SETTLE);
    gates_are("R7 unblocked after low command", 3'b011, 3'b100);
  endtask

  task automatic t_pulse;
    logic seen;
    hi_cmd = '0; lo_cmd = '0;
    wait_cyc(SETTLE);
    lo_cmd[1] = 1'b1;
    wait_cyc(MINPW - 1);
    lo_cmd[1] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      wait_cyc(1);
      seen |= lo_gate[1];
    end
    chk("R9 short on-pulse rejected", 32'(seen), 0);
    lo_cmd[1] = 1'b1;
    wait_cyc(MINPW);
    lo_cmd[1] = 1'b0;
    seen = 1'b0;
    for (int i = 0; i < SETTLE; i++) begin
      wait_cyc(1);
      seen |= lo_gate[1];
    end
    chk("R9 minimum on-pulse passed", 32'(seen), 1);
    lo_cmd[1] = 1'b1;
    wait_cyc(SETTLE);
    lo_cmd[1] = 1'b0;
    wait_cyc(MINPW - 1);
    lo_cmd[1] = 1'b1;
    seen = 1'b1;
    for (int i = 0; i < SETTLE; i++) begin
      wait_cyc(1);
      seen &= lo_gate[1];
    end
    chk("R9 short off-pulse rejected", 32'(seen), 1);
  endtask

  initial begin
    wait_cyc(400000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_interlock();
    t_enable();
    t_trip();
    t_main_uv();
    t_upper_uv();
    t_pulse();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule